// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks the fetch state of every hardware thread in a multithreaded front end. Each cycle it combines the hold and release pulses coming back from the four later pipeline stages, the squash requests from commit and decode, the commit-side "reorder buffer still squashing" indication, a global context-switch stall and the instruction-cache events of each thread. From these it computes each thread's next state under a fixed priority. Each thread also keeps one sticky stall flag per downstream stage.

Whenever a squash is taken, the block emits a one-cycle redirect pulse for that thread. The pulse carries the new fetch address, the following address, and the address one instruction beyond that. A single stage-active output tells the rest of the core whether any enabled thread is in a state that needs the fetch stage clocked this cycle.

All pins are plain control and status signals. There is no data stream, so no port uses a valid/ready handshake and no port applies back-pressure.

Top module: `fetch_status_ctl`

## Requirements
- R1: After reset every thread is Running (code 0), all stall flags are clear, no redirect pulse is raised, and stage_active equals the OR of thread_active. State codes: Running 0, Idle 1, Squashing 2, Blocked 3, wait-response 4, wait-retry 5, access-complete 6, trap-pending 7, quiesce-pending 8.
- R2: Each thread has one sticky stall flag per stage (decode, rename, execute, commit). A hold pulse sets the flag and a release pulse clears it. While any flag is set, a thread that is not waiting on the cache is Blocked. The thread returns to Running on the same edge that clears its last flag. Pulsing hold and release together for the same stage is illegal.
- R3: A commit squash has the highest priority and overrides a decode squash in the same cycle. One cycle later the thread is Squashing and redirect_valid is high for exactly one cycle, with redirect_pc = commit PC, redirect_npc = commit next PC and redirect_nnpc = commit next PC + INST_BYTES.
- R4: When there is no commit squash, the ROB-squashing indication keeps or puts the thread in Squashing. The thread returns to Running after the first cycle in which no squash or stall condition is present.
- R5: A decode squash redirects a thread that is not Squashing, using the decode addresses. A decode squash that arrives while the thread is Squashing is ignored: it raises no pulse and leaves the redirect addresses unchanged.
- R6: Stall flags and the context-switch stall do not move a thread that is in wait-response or wait-retry.
- R7: The context-switch stall blocks every thread that is not waiting on the cache. The threads resume Running when it drops.
- R8: Cache flow for a Running thread. A refused miss goes to wait-retry, an issued miss goes to wait-response, and a retry grant moves wait-retry to wait-response. A response moves wait-response to access-complete, or to Blocked if a stall is active. Access-complete stays put until the thread's fetch_slot, then becomes Running.
- R9: stage_active is high exactly when some thread with thread_active set is Running, Squashing or access-complete.
- R10: A commit squash cancels an outstanding wait-response. The thread becomes Squashing and then Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active | input | NT | Threads counted by stage_active |
| ctx_switch | input | 1 | Global context-switch stall |
| dec_hold | input | NT | Decode hold pulse per thread |
| dec_release | input | NT | Decode release pulse per thread |
| ren_hold | input | NT | Rename hold pulse per thread |
| ren_release | input | NT | Rename release pulse per thread |
| exe_hold | input | NT | Execute hold pulse per thread |
| exe_release | input | NT | Execute release pulse per thread |
| cmt_hold | input | NT | Commit hold pulse per thread |
| cmt_release | input | NT | Commit release pulse per thread |
| cmt_squash | input | NT | Commit squash per thread |
| cmt_pc | input | NT*PC_W | Commit redirect address per thread |
| cmt_npc | input | NT*PC_W | Commit redirect next address per thread |
| rob_squashing | input | NT | Reorder buffer still squashing per thread |
| dec_squash | input | NT | Decode squash per thread |
| dec_pc | input | NT*PC_W | Decode redirect address per thread |
| dec_npc | input | NT*PC_W | Decode redirect next address per thread |
| miss_issue | input | NT | Line request accepted by the cache |
| miss_nack | input | NT | Line request refused by the cache |
| retry_grant | input | NT | Refused request resent and accepted |
| resp_arrive | input | NT | Line data returned |
| fetch_slot | input | NT | Thread selected for fetch this cycle |
| thr_state | output | NT*4 | State code per thread |
| redirect_valid | output | NT | One-cycle redirect pulse per thread |
| redirect_pc | output | NT*PC_W | Last redirect address |
| redirect_npc | output | NT*PC_W | Last redirect next address |
| redirect_nnpc | output | NT*PC_W | Last redirect next address plus one instruction |
| stage_active | output | 1 | Fetch stage needs clocking |

## Verification
The bench builds the block with NT = 3, PC_W = 32 and INST_BYTES = 4. Three threads are enough to show that stall flags, squashes and cache waits stay confined to one thread while the context-switch stall reaches all of them. They also allow a thread_active mask that leaves one thread out, so stage_active can be checked against threads that are present but not enabled. The redirect addresses use next addresses that are not sequential, which separates the next-next result from a plain PC + 8.

// File: rtl/fetch_ctl_pkg.sv
package fetch_ctl_pkg;
  localparam int STATE_W    = 4;
  localparam int NUM_STAGES = 4;

  typedef enum logic [STATE_W-1:0] {
    TS_RUN          = 4'd0,
    TS_IDLE         = 4'd1,
    TS_SQUASH       = 4'd2,
    TS_BLOCKED      = 4'd3,
    TS_WAIT_RESP    = 4'd4,
    TS_WAIT_RETRY   = 4'd5,
    TS_ACC_DONE     = 4'd6,
    TS_TRAP_PEND    = 4'd7,
    TS_QUIESCE_PEND = 4'd8
  } thr_state_e;
endpackage

// File: rtl/fc_stall_bank.sv
module fc_stall_bank #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  output logic          any_next_o
);
  logic [NS-1:0] flag_q;
  logic [NS-1:0] flag_d;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    always_comb begin
      flag_d[s] = flag_q[s];
      if (set_i[s]) flag_d[s] = 1'b1;
      if (clr_i[s]) flag_d[s] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[s] <= 1'b0;
      else        flag_q[s] <= flag_d[s];
    end
  end

  assign any_next_o = |flag_d;
endmodule

// File: rtl/fc_thread_fsm.sv
module fc_thread_fsm
  import fetch_ctl_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_i,
  input  logic            cmt_sq_i,
  input  logic [PC_W-1:0] cmt_pc_i,
  input  logic [PC_W-1:0] cmt_npc_i,
  input  logic            rob_sq_i,
  input  logic            dec_sq_i,
  input  logic [PC_W-1:0] dec_pc_i,
  input  logic [PC_W-1:0] dec_npc_i,
  input  logic            miss_issue_i,
  input  logic            miss_nack_i,
  input  logic            retry_grant_i,
  input  logic            resp_i,
  input  logic            slot_i,
  output thr_state_e      state_o,
  output logic            redir_v_o,
  output logic [PC_W-1:0] redir_pc_o,
  output logic [PC_W-1:0] redir_npc_o,
  output logic [PC_W-1:0] redir_nnpc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  thr_state_e      st_q, st_d;
  logic            load;
  logic [PC_W-1:0] new_pc, new_npc;
  logic            in_cache_wait;

  assign in_cache_wait = (st_q == TS_WAIT_RESP) || (st_q == TS_WAIT_RETRY);

  always_comb begin
    st_d    = st_q;
    load    = 1'b0;
    new_pc  = cmt_pc_i;
    new_npc = cmt_npc_i;
    if (cmt_sq_i) begin
      st_d = TS_SQUASH;
      load = 1'b1;
    end else if (rob_sq_i) begin
      st_d = TS_SQUASH;
    end else if (dec_sq_i && st_q != TS_SQUASH) begin
      st_d    = TS_SQUASH;
      load    = 1'b1;
      new_pc  = dec_pc_i;
      new_npc = dec_npc_i;
    end else if (stall_i && !in_cache_wait) begin
      st_d = TS_BLOCKED;
    end else if (st_q == TS_BLOCKED || st_q == TS_SQUASH) begin
      st_d = TS_RUN;
    end else begin
      unique case (st_q)
        TS_RUN: begin
          if (miss_nack_i)       st_d = TS_WAIT_RETRY;
          else if (miss_issue_i) st_d = TS_WAIT_RESP;
        end
        TS_WAIT_RETRY: if (retry_grant_i) st_d = TS_WAIT_RESP;
        TS_WAIT_RESP:  if (resp_i) st_d = stall_i ? TS_BLOCKED : TS_ACC_DONE;
        TS_ACC_DONE:   if (slot_i) st_d = TS_RUN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= TS_RUN;
      redir_v_o    <= 1'b0;
      redir_pc_o   <= '0;
      redir_npc_o  <= '0;
      redir_nnpc_o <= '0;
    end else begin
      st_q      <= st_d;
      redir_v_o <= load;
      if (load) begin
        redir_pc_o   <= new_pc;
        redir_npc_o  <= new_npc;
        redir_nnpc_o <= new_npc + STEP;
      end
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/fc_activity.sv
module fc_activity
  import fetch_ctl_pkg::*;
#(
  parameter int NT = 2
) (
  input  logic [NT*STATE_W-1:0] states_i,
  input  logic [NT-1:0]         enable_i,
  output logic                  active_o
);
  logic [NT-1:0] wants;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [STATE_W-1:0] s;
    assign s = states_i[t*STATE_W +: STATE_W];
    assign wants[t] = enable_i[t] &&
                      (s == TS_RUN || s == TS_SQUASH || s == TS_ACC_DONE);
  end

  assign active_o = |wants;
endmodule

// File: rtl/fetch_status_ctl.sv
module fetch_status_ctl
  import fetch_ctl_pkg::*;
#(
  parameter int NT         = 2,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NT-1:0]        thread_active,
  input  logic                 ctx_switch,
  input  logic [NT-1:0]        dec_hold,
  input  logic [NT-1:0]        dec_release,
  input  logic [NT-1:0]        ren_hold,
  input  logic [NT-1:0]        ren_release,
  input  logic [NT-1:0]        exe_hold,
  input  logic [NT-1:0]        exe_release,
  input  logic [NT-1:0]        cmt_hold,
  input  logic [NT-1:0]        cmt_release,
  input  logic [NT-1:0]        cmt_squash,
  input  logic [NT*PC_W-1:0]   cmt_pc,
  input  logic [NT*PC_W-1:0]   cmt_npc,
  input  logic [NT-1:0]        rob_squashing,
  input  logic [NT-1:0]        dec_squash,
  input  logic [NT*PC_W-1:0]   dec_pc,
  input  logic [NT*PC_W-1:0]   dec_npc,
  input  logic [NT-1:0]        miss_issue,
  input  logic [NT-1:0]        miss_nack,
  input  logic [NT-1:0]        retry_grant,
  input  logic [NT-1:0]        resp_arrive,
  input  logic [NT-1:0]        fetch_slot,
  output logic [NT*4-1:0]      thr_state,
  output logic [NT-1:0]        redirect_valid,
  output logic [NT*PC_W-1:0]   redirect_pc,
  output logic [NT*PC_W-1:0]   redirect_npc,
  output logic [NT*PC_W-1:0]   redirect_nnpc,
  output logic                 stage_active
);
  for (genvar t = 0; t < NT; t++) begin : g_thread
    logic [NUM_STAGES-1:0] set_v, clr_v;
    logic                  flags_any;
    thr_state_e            st;

    assign set_v = {cmt_hold[t], exe_hold[t], ren_hold[t], dec_hold[t]};
    assign clr_v = {cmt_release[t], exe_release[t], ren_release[t], dec_release[t]};

    fc_stall_bank #(.NS(NUM_STAGES)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_v),
      .clr_i      (clr_v),
      .any_next_o (flags_any)
    );

    fc_thread_fsm #(.PC_W(PC_W), .INST_BYTES(INST_BYTES)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .stall_i       (flags_any | ctx_switch),
      .cmt_sq_i      (cmt_squash[t]),
      .cmt_pc_i      (cmt_pc[t*PC_W +: PC_W]),
      .cmt_npc_i     (cmt_npc[t*PC_W +: PC_W]),
      .rob_sq_i      (rob_squashing[t]),
      .dec_sq_i      (dec_squash[t]),
      .dec_pc_i      (dec_pc[t*PC_W +: PC_W]),
      .dec_npc_i     (dec_npc[t*PC_W +: PC_W]),
      .miss_issue_i  (miss_issue[t]),
      .miss_nack_i   (miss_nack[t]),
      .retry_grant_i (retry_grant[t]),
      .resp_i        (resp_arrive[t]),
      .slot_i        (fetch_slot[t]),
      .state_o       (st),
      .redir_v_o     (redirect_valid[t]),
      .redir_pc_o    (redirect_pc[t*PC_W +: PC_W]),
      .redir_npc_o   (redirect_npc[t*PC_W +: PC_W]),
      .redir_nnpc_o  (redirect_nnpc[t*PC_W +: PC_W])
    );

    assign thr_state[t*4 +: 4] = st;
  end

  fc_activity #(.NT(NT)) u_act (
    .states_i (thr_state),
    .enable_i (thread_active),
    .active_o (stage_active)
  );
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int NT   = 2,
  parameter int PC_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NT-1:0]      thread_active,
  input logic [NT-1:0]      dec_hold,
  input logic [NT-1:0]      dec_release,
  input logic [NT-1:0]      ren_hold,
  input logic [NT-1:0]      ren_release,
  input logic [NT-1:0]      exe_hold,
  input logic [NT-1:0]      exe_release,
  input logic [NT-1:0]      cmt_hold,
  input logic [NT-1:0]      cmt_release,
  input logic [NT-1:0]      cmt_squash,
  input logic [NT*PC_W-1:0] cmt_pc,
  input logic [NT-1:0]      rob_squashing,
  input logic [NT-1:0]      dec_squash,
  input logic [NT-1:0]      resp_arrive,
  input logic [NT*4-1:0]    thr_state,
  input logic [NT-1:0]      redirect_valid,
  input logic [NT*PC_W-1:0] redirect_pc,
  input logic               stage_active
);
  assert_hold_release_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec_hold & dec_release) | (ren_hold & ren_release) |
     (exe_hold & exe_release) | (cmt_hold & cmt_release)) == '0);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    assert_cmt_squash_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_squash[t] |=> redirect_valid[t] && thr_state[t*4 +: 4] == 4'd2 &&
                        redirect_pc[t*PC_W +: PC_W] == $past(cmt_pc[t*PC_W +: PC_W]));

    assert_dec_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_squash[t] && thr_state[t*4 +: 4] == 4'd2 && !cmt_squash[t] && !rob_squashing[t])
      |=> !redirect_valid[t]);

    assert_wait_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_state[t*4 +: 4] == 4'd4 && !cmt_squash[t] && !rob_squashing[t] &&
       !dec_squash[t] && !resp_arrive[t]) |=> thr_state[t*4 +: 4] == 4'd4);

    assert_active_on_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_valid[t] && thread_active[t]) |-> stage_active);
  end
endmodule

bind fetch_status_ctl fc_checker #(.NT(NT), .PC_W(PC_W)) u_fc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .thread_active (thread_active),
  .dec_hold      (dec_hold),
  .dec_release   (dec_release),
  .ren_hold      (ren_hold),
  .ren_release   (ren_release),
  .exe_hold      (exe_hold),
  .exe_release   (exe_release),
  .cmt_hold      (cmt_hold),
  .cmt_release   (cmt_release),
  .cmt_squash    (cmt_squash),
  .cmt_pc        (cmt_pc),
  .rob_squashing (rob_squashing),
  .dec_squash    (dec_squash),
  .resp_arrive   (resp_arrive),
  .thr_state     (thr_state),
  .redirect_valid(redirect_valid),
  .redirect_pc   (redirect_pc),
  .stage_active  (stage_active)
);

// File: tb/test_fetch_status_ctl.sv
module test_fetch_status_ctl;
  localparam int NT = 3;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [NT-1:0] thread_active;
  logic ctx_switch;
  logic [NT-1:0] dec_hold, dec_release, ren_hold, ren_release;
  logic [NT-1:0] exe_hold, exe_release, cmt_hold, cmt_release;
  logic [NT-1:0] cmt_squash, rob_squashing, dec_squash;
  logic [NT*PW-1:0] cmt_pc, cmt_npc, dec_pc, dec_npc;
  logic [NT-1:0] miss_issue, miss_nack, retry_grant, resp_arrive, fetch_slot;
  logic [NT*4-1:0] thr_state;
  logic [NT-1:0] redirect_valid;
  logic [NT*PW-1:0] redirect_pc, redirect_npc, redirect_nnpc;
  logic stage_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fetch_status_ctl #(.NT(NT), .PC_W(PW), .INST_BYTES(4)) i_fetch_status_ctl (
    .clk(clk), .rst_n(rst_n), .thread_active(thread_active), .ctx_switch(ctx_switch),
    .dec_hold(dec_hold), .dec_release(dec_release), .ren_hold(ren_hold),
    .ren_release(ren_release), .exe_hold(exe_hold), .exe_release(exe_release),
    .cmt_hold(cmt_hold), .cmt_release(cmt_release), .cmt_squash(cmt_squash),
    .cmt_pc(cmt_pc), .cmt_npc(cmt_npc), .rob_squashing(rob_squashing),
    .dec_squash(dec_squash), .dec_pc(dec_pc), .dec_npc(dec_npc),
    .miss_issue(miss_issue), .miss_nack(miss_nack), .retry_grant(retry_grant),
    .resp_arrive(resp_arrive), .fetch_slot(fetch_slot), .thr_state(thr_state),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .redirect_npc(redirect_npc), .redirect_nnpc(redirect_nnpc),
    .stage_active(stage_active)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] st(input int t);
    return 32'(thr_state[t*4 +: 4]);
  endfunction

  task automatic clear_pulses();
    ctx_switch = 0;
    dec_hold = '0; dec_release = '0; ren_hold = '0; ren_release = '0;
    exe_hold = '0; exe_release = '0; cmt_hold = '0; cmt_release = '0;
    cmt_squash = '0; rob_squashing = '0; dec_squash = '0;
    miss_issue = '0; miss_nack = '0; retry_grant = '0; resp_arrive = '0; fetch_slot = '0;
  endtask

  // Advance one edge, then drop single-cycle inputs; outputs are sampled 2 ns later.
  task automatic cyc();
    @(posedge clk);
    #2;
    clear_pulses();
  endtask

  task automatic t_reset();
    chk("R1 state t0", st(0), 0);
    chk("R1 state t2", st(2), 0);
    chk("R1 redirect", 32'(redirect_valid), 0);
    chk("R1 stage_active", 32'(stage_active), 1);
  endtask

  task automatic t_sticky();
    dec_hold[0] = 1; cyc();
    chk("R2 blocked by decode hold", st(0), 3);
    chk("R2 other thread running", st(1), 0);
    cyc();
    chk("R2 flag sticky", st(0), 3);
    ren_hold[0] = 1; cyc();
    dec_release[0] = 1; cyc();
    chk("R2 rename flag still holds", st(0), 3);
    ren_release[0] = 1; cyc();
    chk("R2 last release resumes", st(0), 0);
  endtask

  task automatic t_cmt_squash();
    cmt_squash[1] = 1; cmt_pc[PW +: PW] = 32'h1000; cmt_npc[PW +: PW] = 32'h2000;
    dec_squash[1] = 1; dec_pc[PW +: PW] = 32'h5000; dec_npc[PW +: PW] = 32'h5004;
    cyc();
    chk("R3 squashing", st(1), 2);
    chk("R3 pulse", 32'(redirect_valid[1]), 1);
    chk("R3 pc wins over decode", redirect_pc[PW +: PW], 32'h1000);
    chk("R3 npc", redirect_npc[PW +: PW], 32'h2000);
    chk("R3 nnpc", redirect_nnpc[PW +: PW], 32'h2004);
    cyc();
    chk("R3 pulse one cycle", 32'(redirect_valid[1]), 0);
    chk("R4 back to running", st(1), 0);
  endtask

  task automatic t_rob();
    cmt_squash[0] = 1; cmt_pc[PW-1:0] = 32'h40; cmt_npc[PW-1:0] = 32'h44; cyc();
    rob_squashing[0] = 1; cyc();
    chk("R4 rob keeps squashing", st(0), 2);
    chk("R4 rob no pulse", 32'(redirect_valid[0]), 0);
    rob_squashing[0] = 1; cyc();
    chk("R4 rob keeps squashing 2", st(0), 2);
    cyc();
    chk("R4 resumes", st(0), 0);
  endtask

  task automatic t_dec_squash();
    dec_squash[0] = 1; dec_pc[PW-1:0] = 32'h400; dec_npc[PW-1:0] = 32'h404; cyc();
    chk("R5 decode squash taken", st(0), 2);
    chk("R5 decode pc", redirect_pc[PW-1:0], 32'h400);
    chk("R5 decode nnpc", redirect_nnpc[PW-1:0], 32'h408);
    dec_squash[0] = 1; dec_pc[PW-1:0] = 32'h800; dec_npc[PW-1:0] = 32'h804; cyc();
    chk("R5 ignored no pulse", 32'(redirect_valid[0]), 0);
    chk("R5 ignored pc kept", redirect_pc[PW-1:0], 32'h400);
    chk("R5 state running", st(0), 0);
  endtask

  task automatic t_cache();
    miss_issue[0] = 1; cyc();
    chk("R8 issue -> wait-response", st(0), 4);
    exe_hold[0] = 1; cyc();
    chk("R6 stall ignored in wait-response", st(0), 4);
    resp_arrive[0] = 1; cyc();
    chk("R8 response while stalled -> blocked", st(0), 3);
    exe_release[0] = 1; cyc();
    chk("R8 resumes", st(0), 0);
    miss_nack[0] = 1; cyc();
    chk("R8 nack -> wait-retry", st(0), 5);
    cmt_hold[0] = 1; cyc();
    chk("R6 stall ignored in wait-retry", st(0), 5);
    retry_grant[0] = 1; cyc();
    chk("R8 grant -> wait-response", st(0), 4);
    cmt_release[0] = 1; cyc();
    resp_arrive[0] = 1; cyc();
    chk("R8 response -> access-complete", st(0), 6);
    cyc();
    chk("R8 waits for slot", st(0), 6);
    fetch_slot[0] = 1; cyc();
    chk("R8 slot -> running", st(0), 0);
  endtask

  task automatic t_ctx();
    ctx_switch = 1; cyc();
    chk("R7 t0 blocked", st(0), 3);
    chk("R7 t2 blocked", st(2), 3);
    chk("R9 all blocked inactive", 32'(stage_active), 0);
    cyc();
    chk("R7 t1 resumes", st(1), 0);
  endtask

  task automatic t_squash_wait();
    miss_issue[1] = 1; cyc();
    chk("R10 waiting", st(1), 4);
    cmt_squash[1] = 1; cmt_pc[PW +: PW] = 32'h300; cmt_npc[PW +: PW] = 32'h304; cyc();
    chk("R10 squash cancels wait", st(1), 2);
    cyc();
    chk("R10 then running", st(1), 0);
  endtask

  task automatic t_active();
    miss_issue[0] = 1; dec_hold[1] = 1; cyc();
    chk("R9 t2 disabled, others parked", 32'(stage_active), 0);
    thread_active = 3'b100; #1;
    chk("R9 enabled t2 running", 32'(stage_active), 1);
    thread_active = 3'b011; resp_arrive[0] = 1; cyc();
    chk("R9 access-complete counts", 32'(stage_active), 1);
    fetch_slot[0] = 1; dec_release[1] = 1; cyc();
  endtask

  initial begin
    thread_active = 3'b011;
    cmt_pc = '0; cmt_npc = '0; dec_pc = '0; dec_npc = '0;
    clear_pulses();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    t_reset();
    t_sticky();
    t_cmt_squash();
    t_rob();
    t_dec_squash();
    t_cache();
    t_ctx();
    t_squash_wait();
    t_active();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule